// File: doc/BRIEF.md
# Tagged Result Queue with Status Word

This block stores conversion results in arrival order and answers two host commands: one removes and returns the oldest stored result, the other returns a status word. Every stored entry is 16 bits wide. A 4-bit channel tag sits in the top nibble and a 12-bit value fills the low bits. A producer pushes one entry per cycle with a single strobe. The host issues an 8-bit command code with a valid strobe and gets a registered response one cycle later.

The status word gathers several items. Two are sticky events: a restart indication, and a queue overflow indication. The word also shows the queue-empty state and four busy indications taken from outside engines. A clear strobe empties the queue. A mode input switches between result monitoring and table readback. In table readback the queue never overflows, and the overflow bit instead shows the live table-full input. The serial transport, the converter, the arithmetic engine and the table memory all sit outside this block; their states arrive as plain inputs.

Top module: `tagged_result_queue`

## Requirements
- R1: While `rst_n` is low, `rsp_valid` is 0. A status read issued on the first clock after reset release returns 16'h0006: only the bit-2 busy and bit-1 empty bits are set.
- R2: A pushed entry is `{push_tag, push_value}`, with the tag in bits 15:12 and the value in bits 11:0. Pops return entries oldest first.
- R3: Command code 8'h80 pops, and command code 8'hF6 reads the status word. The matching response appears on `rsp_valid`/`rsp_data` in the cycle after the command. Any other code produces no response and changes no state.
- R4: The status word has bit 6 restart, bit 5 arithmetic busy, bit 4 gain-calibration busy, bit 3 converter busy, bit 2 lookup busy, bit 1 empty and bit 0 overflow. Bits 15:7 read as 0.
- R5: A `wdog_restart` or `soft_restart` pulse sets the restart bit. A status read returns the bit as it was before the read and clears it on the next cycle. If a set pulse arrives in the same cycle as a read, the bit is left set.
- R6: The empty bit is 1 exactly when the queue holds no entry. A `fifo_clr` pulse discards every entry.
- R7: In monitoring mode (`table_mode`=0), a push into a full queue is discarded and sets the sticky overflow bit. Only a status read or `fifo_clr` clears that bit; draining the queue does not.
- R8: In table-readback mode (`table_mode`=1), status bit 0 equals `table_full` at the command cycle. A push into a full queue is discarded without setting the sticky overflow.
- R9: A pop on an empty queue returns a response with data 0 and changes no state.
- R10: A push and a pop in the same cycle on a non-empty queue keep the entry count unchanged, and the pop returns the oldest entry.
- R11: Each busy bit is the value of its input sampled at the previous clock edge.
- R12: The queue holds `DEPTH` entries, 16 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wdog_restart | input | 1 | Pulse: a watchdog restart occurred |
| soft_restart | input | 1 | Pulse: a software full restart was commanded |
| fifo_clr | input | 1 | Pulse: discard all queued entries and the sticky overflow |
| push_valid | input | 1 | Producer push strobe |
| push_tag | input | 4 | Channel tag of the pushed result |
| push_value | input | 12 | Result value, MSB in bit 11 |
| cmd_valid | input | 1 | Host command strobe |
| cmd_code | input | 8 | Host command code |
| table_mode | input | 1 | 1 = table readback, 0 = result monitoring |
| table_full | input | 1 | Table-full state from the table memory |
| alu_busy_in | input | 1 | Arithmetic engine busy on other tasks |
| pga_busy_in | input | 1 | Gain calibration in progress |
| adc_busy_in | input | 1 | Converter scan in progress |
| vg_busy_in | input | 1 | Lookup/interpolation in progress |
| rsp_valid | output | 1 | Response valid, one cycle after a decoded command |
| rsp_data | output | 16 | Popped entry or status word |

## Verification
On every cycle, the assertions check the counting rules of the queue: a discarded push into a full queue, a push and pop together, an empty pop, and a clear. They also check that the sticky bits are set after their events, that the busy bits follow their inputs with one cycle of delay, and that the response appears one cycle after a command. Only the bench scenarios can show the actual data order and the exact status word values. These include reading the sticky bits before they clear, a set event winning over a read in the same cycle, the overflow surviving a drain, and the bit-0 substitution in table-readback mode.

// File: rtl/rfq_pkg.sv
package rfq_pkg;
  parameter int TAG_W = 4;
  parameter int VAL_W = 12;
  localparam int WORD_W = TAG_W + VAL_W;
  localparam int FLAG_BITS = 7;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [7:0] {
    OP_POP   = 8'h80,
    OP_STATE = 8'hF6
  } host_op_e;

  // order is the status word layout, MSB first (bit 6 .. bit 0)
  typedef struct packed {
    logic restart;
    logic alu_busy;
    logic pga_busy;
    logic adc_busy;
    logic vg_busy;
    logic empty;
    logic ovr;
  } status_t;

  function automatic word_t pack_entry(input logic [TAG_W-1:0] tag,
                                       input logic [VAL_W-1:0] val);
    return {tag, val};
  endfunction

  function automatic word_t status_to_word(input status_t s);
    word_t w;
    w = '0;
    w[FLAG_BITS-1:0] = s;
    return w;
  endfunction
endpackage

// File: rtl/rfq_store.sv
module rfq_store
  import rfq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push_req,
  input  word_t push_word,
  input  logic  pop_req,
  input  logic  clr,
  output word_t head_word,
  output logic  is_empty,
  output logic  pop_fire,
  output logic  full_push_evt
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  word_t            mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             is_full;
  logic             push_fire;

  assign is_empty      = (count == '0);
  assign is_full       = (count == CNT_MAX);
  assign pop_fire      = pop_req && !is_empty && !clr;
  assign push_fire     = push_req && !clr && (!is_full || pop_fire);
  assign full_push_evt = push_req && !clr && is_full && !pop_fire;
  assign head_word     = is_empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_fire) mem[wr_ptr] <= push_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_fire) wr_ptr <= ptr_step(wr_ptr);
      if (pop_fire)  rd_ptr <= ptr_step(rd_ptr);
      if (push_fire && !pop_fire)      count <= count + 1'b1;
      else if (pop_fire && !push_fire) count <= count - 1'b1;
    end
  end

  // R7: discarded push leaves the count unchanged
  a_r7_full_push_kept: assert property (@(posedge clk) disable iff (!rst_n)
    full_push_evt |=> count == $past(count));
  // R10: simultaneous push and pop on a non-empty queue
  a_r10_push_pop_count: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && pop_req && !is_empty && !clr) |=> count == $past(count));
  // R9: pop on empty without push leaves the queue unchanged
  a_r9_empty_pop_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && is_empty && !push_req) |=> $stable(count) && $stable(rd_ptr));
  // R6: clear empties the queue
  a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> is_empty);
  // R12: count never exceeds depth
  a_r12_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_MAX);
endmodule

// File: rtl/rfq_status.sv
module rfq_status
  import rfq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  restart_evt,
  input  logic  state_read,
  input  logic  full_push_evt,
  input  logic  clr,
  input  logic  table_mode,
  input  logic  table_full,
  input  logic  q_empty,
  input  logic  alu_busy_in,
  input  logic  pga_busy_in,
  input  logic  adc_busy_in,
  input  logic  vg_busy_in,
  output word_t status_word
);
  logic    restart_q, ovr_q;
  logic    alu_q, pga_q, adc_q, vg_q;
  logic    ovr_set;
  status_t st;

  assign ovr_set = full_push_evt && !table_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      restart_q <= 1'b0;
      ovr_q     <= 1'b0;
      alu_q     <= 1'b0;
      pga_q     <= 1'b0;
      adc_q     <= 1'b0;
      vg_q      <= 1'b1;
    end else begin
      if (restart_evt)     restart_q <= 1'b1;
      else if (state_read) restart_q <= 1'b0;
      if (ovr_set)                 ovr_q <= 1'b1;
      else if (state_read || clr)  ovr_q <= 1'b0;
      alu_q <= alu_busy_in;
      pga_q <= pga_busy_in;
      adc_q <= adc_busy_in;
      vg_q  <= vg_busy_in;
    end
  end

  always_comb begin
    st.restart  = restart_q;
    st.alu_busy = alu_q;
    st.pga_busy = pga_q;
    st.adc_busy = adc_q;
    st.vg_busy  = vg_q;
    st.empty    = q_empty;
    st.ovr      = table_mode ? table_full : ovr_q;
  end

  assign status_word = status_to_word(st);

  // R5: a restart event always leaves the bit set
  a_r5_restart_set: assert property (@(posedge clk) disable iff (!rst_n)
    restart_evt |=> restart_q);
  // R7: overflow in monitoring mode leaves the sticky bit set
  a_r7_ovr_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_set |=> ovr_q);
  // R8: table mode never sets the sticky bit
  a_r8_no_sticky_in_table: assert property (@(posedge clk) disable iff (!rst_n)
    (table_mode && !ovr_q) |=> !ovr_q);
  // R11: busy bits follow their inputs after one edge
  a_r11_busy_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (alu_q == $past(alu_busy_in)) && (pga_q == $past(pga_busy_in))
          && (adc_q == $past(adc_busy_in)) && (vg_q == $past(vg_busy_in)));
endmodule

// File: rtl/tagged_result_queue.sv
module tagged_result_queue
  import rfq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wdog_restart,
  input  logic              soft_restart,
  input  logic              fifo_clr,
  input  logic              push_valid,
  input  logic [TAG_W-1:0]  push_tag,
  input  logic [VAL_W-1:0]  push_value,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic              table_mode,
  input  logic              table_full,
  input  logic              alu_busy_in,
  input  logic              pga_busy_in,
  input  logic              adc_busy_in,
  input  logic              vg_busy_in,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data
);
  logic  cmd_pop, cmd_state;
  logic  pop_fire, q_empty, full_push_evt;
  word_t head_word, status_word;

  assign cmd_pop   = cmd_valid && (cmd_code == OP_POP);
  assign cmd_state = cmd_valid && (cmd_code == OP_STATE);

  rfq_store #(.DEPTH(DEPTH)) u_store (
    .clk           (clk),
    .rst_n         (rst_n),
    .push_req      (push_valid),
    .push_word     (pack_entry(push_tag, push_value)),
    .pop_req       (cmd_pop),
    .clr           (fifo_clr),
    .head_word     (head_word),
    .is_empty      (q_empty),
    .pop_fire      (pop_fire),
    .full_push_evt (full_push_evt)
  );

  rfq_status u_status (
    .clk           (clk),
    .rst_n         (rst_n),
    .restart_evt   (wdog_restart || soft_restart),
    .state_read    (cmd_state),
    .full_push_evt (full_push_evt),
    .clr           (fifo_clr),
    .table_mode    (table_mode),
    .table_full    (table_full),
    .q_empty       (q_empty),
    .alu_busy_in   (alu_busy_in),
    .pga_busy_in   (pga_busy_in),
    .adc_busy_in   (adc_busy_in),
    .vg_busy_in    (vg_busy_in),
    .status_word   (status_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= cmd_pop || cmd_state;
      if (cmd_state)    rsp_data <= status_word;
      else if (cmd_pop) rsp_data <= pop_fire ? head_word : '0;
    end
  end

  // R3: decoded commands answer in the next cycle, others never do
  a_r3_rsp_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pop || cmd_state) |=> rsp_valid);
  a_r3_no_rsp_unknown: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_pop || cmd_state) |=> !rsp_valid);
  // R4: the upper bits of any status response are zero
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_state |=> rsp_data[WORD_W-1:FLAG_BITS] == '0);
endmodule

// File: tb/test_tagged_result_queue.sv
module test_tagged_result_queue;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wdog_restart = 0, soft_restart = 0, fifo_clr = 0;
  logic        push_valid = 0;
  logic [3:0]  push_tag = 0;
  logic [11:0] push_value = 0;
  logic        cmd_valid = 0;
  logic [7:0]  cmd_code = 0;
  logic        table_mode = 0, table_full = 0;
  logic        alu_busy_in = 0, pga_busy_in = 0, adc_busy_in = 0, vg_busy_in = 0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  int          total = 0, bad = 0;

  always #4 clk = ~clk;

  tagged_result_queue i_tagged_result_queue (
    .clk(clk), .rst_n(rst_n), .wdog_restart(wdog_restart), .soft_restart(soft_restart),
    .fifo_clr(fifo_clr), .push_valid(push_valid), .push_tag(push_tag),
    .push_value(push_value), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .table_mode(table_mode), .table_full(table_full), .alu_busy_in(alu_busy_in),
    .pga_busy_in(pga_busy_in), .adc_busy_in(adc_busy_in), .vg_busy_in(vg_busy_in),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] entry(input int tag, input int val);
    return {tag[3:0], val[11:0]};
  endfunction

  // command issued for one cycle; returns the response seen afterwards
  task automatic cmd(input logic [7:0] code, output logic v, output logic [15:0] d);
    @(negedge clk); cmd_valid = 1; cmd_code = code;
    @(negedge clk); cmd_valid = 0; v = rsp_valid; d = rsp_data;
  endtask

  task automatic push(input int tag, input int val);
    @(negedge clk); push_valid = 1; push_tag = tag[3:0]; push_value = val[11:0];
    @(negedge clk); push_valid = 0;
  endtask

  task automatic expect_status(input string req, input logic [15:0] exp);
    logic v; logic [15:0] d;
    cmd(8'hF6, v, d);
    check(req, {15'd0, v, d}, {15'd0, 1'b1, exp});
  endtask

  task automatic expect_pop(input string req, input logic [15:0] exp);
    logic v; logic [15:0] d;
    cmd(8'h80, v, d);
    check(req, {15'd0, v, d}, {15'd0, 1'b1, exp});
  endtask

  task automatic t_reset;
    logic v; logic [15:0] d;
    vg_busy_in = 0;
    repeat (3) @(negedge clk);
    check("R1 rsp_valid in reset", rsp_valid, 0);
    rst_n = 1; cmd_valid = 1; cmd_code = 8'hF6;   // first edge after release
    @(negedge clk); cmd_valid = 0; v = rsp_valid; d = rsp_data;
    check("R1 R4 reset status", {v, d}, {1'b1, 16'h0006});
    expect_status("R11 vg busy follows input", 16'h0002);
  endtask

  task automatic t_order;
    for (int i = 0; i < 5; i++) push(i + 3, 12'h800 + i * 17);
    expect_status("R6 not empty after push", 16'h0000);
    for (int i = 0; i < 5; i++) expect_pop("R2 oldest first", entry(i + 3, 12'h800 + i * 17));
    expect_status("R6 empty after drain", 16'h0002);
  endtask

  task automatic t_unknown_cmd;
    logic v; logic [15:0] d;
    push(9, 12'hABC);
    cmd(8'h81, v, d);
    check("R3 unknown code no response", v, 0);
    cmd(8'h76, v, d);
    check("R3 unknown code no response", v, 0);
    expect_pop("R3 unknown code left entry", entry(9, 12'hABC));
  endtask

  task automatic t_empty_pop;
    expect_pop("R9 empty pop returns zero", 16'h0000);
    expect_status("R9 state unchanged", 16'h0002);
  endtask

  task automatic t_push_pop;
    push(1, 11); push(2, 22);
    @(negedge clk); push_valid = 1; push_tag = 3; push_value = 33; cmd_valid = 1; cmd_code = 8'h80;
    @(negedge clk); push_valid = 0; cmd_valid = 0;
    check("R10 simultaneous pop data", {rsp_valid, rsp_data}, {1'b1, entry(1, 11)});
    expect_pop("R10 second", entry(2, 22));
    expect_pop("R10 third", entry(3, 33));
    expect_status("R10 empty after", 16'h0002);
  endtask

  task automatic t_restart;
    @(negedge clk); wdog_restart = 1;
    @(negedge clk); wdog_restart = 0;
    expect_status("R5 restart after watchdog", 16'h0042);
    expect_status("R5 restart cleared by read", 16'h0002);
    @(negedge clk); soft_restart = 1; cmd_valid = 1; cmd_code = 8'hF6;
    @(negedge clk); soft_restart = 0; cmd_valid = 0;
    check("R5 read sees prior value", rsp_data, 16'h0002);
    expect_status("R5 set wins over read", 16'h0042);
    expect_status("R5 cleared", 16'h0002);
  endtask

  task automatic t_overflow;
    for (int i = 0; i < 16; i++) push(i, i * 100);
    push(15, 12'hFFF);
    expect_status("R7 R12 overflow sticky", 16'h0001);
    expect_status("R7 cleared by read", 16'h0000);
    push(14, 12'hEEE);
    for (int i = 0; i < 16; i++) expect_pop("R7 R12 stored data kept", entry(i, i * 100));
    expect_pop("R7 discarded word absent", 16'h0000);
    expect_status("R7 drain keeps overflow", 16'h0003);
    expect_status("R7 cleared by read after drain", 16'h0002);
  endtask

  task automatic t_clear;
    for (int i = 0; i < 17; i++) push(5, i);
    @(negedge clk); fifo_clr = 1;
    @(negedge clk); fifo_clr = 0;
    expect_status("R6 R7 clear empties and drops overflow", 16'h0002);
    expect_pop("R6 nothing after clear", 16'h0000);
  endtask

  task automatic t_table;
    table_mode = 1; table_full = 1;
    expect_status("R8 bit0 shows table full", 16'h0003);
    table_full = 0;
    expect_status("R8 bit0 follows table full", 16'h0002);
    for (int i = 0; i < 17; i++) push(7, i + 1);
    expect_status("R8 no overflow in table mode", 16'h0000);
    table_mode = 0;
    expect_status("R8 sticky not set", 16'h0000);
    for (int i = 0; i < 16; i++) expect_pop("R8 data kept", entry(7, i + 1));
    expect_pop("R8 extra push discarded", 16'h0000);
  endtask

  task automatic t_busy;
    logic v; logic [15:0] d;
    @(negedge clk);
    alu_busy_in = 1; pga_busy_in = 1; adc_busy_in = 1; vg_busy_in = 1;
    cmd_valid = 1; cmd_code = 8'hF6;
    @(negedge clk); cmd_valid = 0; v = rsp_valid; d = rsp_data;
    check("R11 busy one cycle late", {v, d}, {1'b1, 16'h0002});
    expect_status("R11 R4 busy bits", 16'h003E);
    alu_busy_in = 0; adc_busy_in = 0; vg_busy_in = 0;
    @(negedge clk);
    expect_status("R11 R4 pga only", 16'h0012);
    pga_busy_in = 0;
  endtask

  initial begin
    t_reset();
    t_order();
    t_unknown_cmd();
    t_empty_pop();
    t_push_pop();
    t_restart();
    t_overflow();
    t_clear();
    t_table();
    t_busy();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule